// File: doc/BRIEF.md
# Gated 16-bit Timer/Event Counter

This block holds a 16-bit count made of two cascaded bytes. While enabled, it either advances on a prescaled peripheral tick (timer mode) or on falling edges of an external event pin (event mode). The event pin is sampled once per peripheral cycle. When the count wraps from all ones to all zeros, a sticky overflow flag is set, and that flag drives the interrupt request.

Counting is enabled by a run input. A gate option hands run control to an external gate pin: with gating on, the count advances only while that pin is high. A double-speed input shortens the peripheral cycle from 12 clocks to 6. Either count byte can be preset through a one-byte write port while the unit is stopped. The overflow flag is cleared by a software clear pulse or by an interrupt acknowledge pulse.

A three-state machine controls counting:
- STOPPED means run is low.
- WAIT_GATE means run is high but the gate holds the count.
- COUNTING means the count may advance.

Its transitions are:
- STOPPED→COUNTING when run rises and the gate is open.
- STOPPED→WAIT_GATE when run rises and the gate is closed.
- WAIT_GATE→COUNTING when the gate opens.
- COUNTING→WAIT_GATE when the gate closes.
- WAIT_GATE→STOPPED and COUNTING→STOPPED when run falls.

Top module: `tmr_gated_unit`

## Requirements
- R1: After reset, both count bytes read 0x00, and ovf_flag and irq are low.
- R2: In timer mode with x2_en low, the count advances once every 12 clocks. N clock edges after run_en rises, the count has grown by floor(N/12).
- R3: In timer mode with x2_en high, the count advances once every 6 clocks.
- R4: When the low byte wraps from 0xFF to 0x00, the high byte increments in the same cycle.
- R5: When the 16-bit count wraps from 0xFFFF to 0x0000, ovf_flag is set. irq is high whenever ovf_flag is high.
- R6: ovf_flag stays set until flag_clr or irq_ack is pulsed. If a clear and a new overflow arrive in the same cycle, the flag stays set.
- R7: Raising run_en does not clear the count. While run_en is low the count holds. The 6/12-clock divider restarts from zero, so after run_en rises again the next step comes a full period later.
- R8: In event mode (evt_mode high), evt_pin passes through a two-flop synchroniser and is sampled once per peripheral cycle. The count advances only when a high sample is followed by a low sample. The peripheral tick alone does not advance it.
- R9: With gate_en low, gate_pin has no effect. With gate_en and run_en both high, counting happens only while gate_pin (after a two-flop synchroniser) is high.
- R10: A wr_en pulse with run_en low loads wr_data into the low byte when wr_hi is 0, and into the high byte when wr_hi is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable |
| x2_en | input | 1 | Double-speed: 6-clock peripheral cycle instead of 12 |
| evt_mode | input | 1 | 0 = timer (count ticks), 1 = event (count pin falls) |
| gate_en | input | 1 | Give run control to gate_pin |
| gate_pin | input | 1 | External gate level, asynchronous |
| evt_pin | input | 1 | External event input, asynchronous |
| wr_en | input | 1 | Byte preset strobe |
| wr_hi | input | 1 | Byte select: 0 low, 1 high |
| wr_data | input | 8 | Preset value |
| flag_clr | input | 1 | Software clear pulse for the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge pulse, also clears the flag |
| count_lo | output | 8 | Low count byte |
| count_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
In timer mode the first step appears on the clock edge 12 (or 6) edges after run_en is driven high, and each later step comes one period after the one before. The bench samples at the falling clock edge after exactly N rising edges, one edge short of a step and again on it.

Overflow and its flag land on the same edge as the wrapping step. A clear pulse acts at the next rising edge.

Changes on gate_pin and evt_pin reach the count only after two synchroniser flops, a state-register cycle and the next peripheral tick, so the exact step cannot be known in advance. For those, the bench waits many peripheral cycles and either compares against an allowed window of step counts or checks that the count is frozen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED   = 2'd0,
        ST_WAIT_GATE = 2'd1,
        ST_COUNTING  = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= {ff_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PER_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic x2,
    output logic tick
);
    localparam int STD_LIM = 2 * PER_CLKS;
    localparam int DIV_W   = $clog2(STD_LIM);
    localparam logic [DIV_W-1:0] STD_END = DIV_W'(STD_LIM - 1);
    localparam logic [DIV_W-1:0] X2_END  = DIV_W'(PER_CLKS - 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] end_val;

    assign end_val = x2 ? X2_END : STD_END;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (!run)             div_q <= '0;
        else if (div_q >= end_val) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
    end

    assign tick = run && (div_q == end_val);
endmodule

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample_en,
    input  logic din,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_q <= 1'b0;
        else if (clear)     prev_q <= 1'b0;
        else if (sample_en) prev_q <= din;
    end

    assign fall = sample_en && prev_q && !din;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int BYTE_W = 8,
    parameter int NB     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [NB*BYTE_W-1:0]   cnt,
    output logic                   ovf
);
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0][BYTE_W-1:0] cnt_q;
    logic [NB:0]               carry;

    assign carry[0] = inc && !wr_en;

    generate
        for (genvar i = 0; i < NB; i++) begin : g_byte
            assign carry[i+1] = carry[i] & (&cnt_q[i]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q[i] <= '0;
                end else if (wr_en) begin
                    if (wr_idx == IDX_W'(i)) cnt_q[i] <= wr_data;
                end else if (carry[i]) begin
                    cnt_q[i] <= cnt_q[i] + 1'b1;
                end
            end
        end
    endgenerate

    assign cnt = cnt_q;
    assign ovf = carry[NB];
endmodule

// File: rtl/tmr_gated_unit.sv
module tmr_gated_unit #(
    parameter int BYTE_W      = 8,
    parameter int PER_CLKS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              x2_en,
    input  logic              evt_mode,
    input  logic              gate_en,
    input  logic              gate_pin,
    input  logic              evt_pin,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              irq_ack,
    output logic [BYTE_W-1:0] count_lo,
    output logic [BYTE_W-1:0] count_hi,
    output logic              ovf_flag,
    output logic              irq
);
    import tmr_pkg::*;

    localparam int NB    = 2;
    localparam int CNT_W = NB * BYTE_W;

    logic             gate_s;
    logic             evt_s;
    logic             tick;
    logic             fall;
    logic             inc;
    logic             ovf;
    logic             flag_q;
    logic [CNT_W-1:0] cnt;
    logic             gate_open;
    tmr_state_e       state_q;
    tmr_state_e       state_d;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(gate_s)
    );

    tmr_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .d(evt_pin), .q(evt_s)
    );

    tmr_prescale #(.PER_CLKS(PER_CLKS)) u_prescale (
        .clk(clk), .rst_n(rst_n), .run(run_en), .x2(x2_en), .tick(tick)
    );

    tmr_fall_detect u_fall (
        .clk(clk), .rst_n(rst_n), .clear(!run_en),
        .sample_en(tick), .din(evt_s), .fall(fall)
    );

    tmr_count #(.BYTE_W(BYTE_W), .NB(NB)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(inc), .wr_en(wr_en),
        .wr_idx(wr_hi), .wr_data(wr_data), .cnt(cnt), .ovf(ovf)
    );

    assign gate_open = !gate_en || gate_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (run_en) state_d = gate_open ? ST_COUNTING : ST_WAIT_GATE;
            end
            ST_WAIT_GATE: begin
                if (!run_en)        state_d = ST_STOPPED;
                else if (gate_open) state_d = ST_COUNTING;
            end
            ST_COUNTING: begin
                if (!run_en)         state_d = ST_STOPPED;
                else if (!gate_open) state_d = ST_WAIT_GATE;
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        inc = 1'b0;
        unique case (state_q)
            ST_COUNTING:  inc = evt_mode ? fall : tick;
            ST_STOPPED,
            ST_WAIT_GATE: inc = 1'b0;
            default:      inc = 1'b0;
        endcase
    end

    // sticky overflow flag, a new overflow wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (ovf)                 flag_q <= 1'b1;
        else if (flag_clr || irq_ack) flag_q <= 1'b0;
    end

    assign count_lo = cnt[BYTE_W-1:0];
    assign count_hi = cnt[CNT_W-1:BYTE_W];
    assign ovf_flag = flag_q;
    assign irq      = flag_q;
endmodule

// File: rtl/tmr_gated_chk.sv
module tmr_gated_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_en,
    input logic                wr_en,
    input logic                flag_clr,
    input logic                irq_ack,
    input logic [BYTE_W-1:0]   count_lo,
    input logic [BYTE_W-1:0]   count_hi,
    input logic                ovf_flag,
    input tmr_pkg::tmr_state_e st
);
    import tmr_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cnt;
    assign cnt = {count_hi, count_lo};

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> $stable(cnt)); // R7

    AST_NOT_COUNTING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_COUNTING && !wr_en) |=> $stable(cnt)); // R9

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && cnt != $past(cnt)) |-> cnt == CNT_W'($past(cnt) + 1'b1)); // R2

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(cnt) == '1 && cnt == '0) |-> ovf_flag); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr && !irq_ack) |=> ovf_flag); // R6

    AST_FLAG_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> cnt == '0); // R5
endmodule

bind tmr_gated_unit tmr_gated_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .count_lo(count_lo),
    .count_hi(count_hi), .ovf_flag(ovf_flag), .st(state_q)
);

// File: tb/tb_tmr_gated_unit.sv
module tb_tmr_gated_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, x2_en = 1'b0, evt_mode = 1'b0, gate_en = 1'b0;
    logic       gate_pin = 1'b0, evt_pin = 1'b0;
    logic       wr_en = 1'b0, wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_clr = 1'b0, irq_ack = 1'b0;
    logic [7:0] count_lo, count_hi;
    logic       ovf_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    tmr_gated_unit dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .x2_en(x2_en),
        .evt_mode(evt_mode), .gate_en(gate_en), .gate_pin(gate_pin),
        .evt_pin(evt_pin), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .flag_clr(flag_clr), .irq_ack(irq_ack), .count_lo(count_lo),
        .count_hi(count_hi), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic int cnt_now();
        return int'({count_hi, count_lo});
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_rng(string req, int act, int lo, int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_byte(bit hi, logic [7:0] d);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_hi = 1'b0;
    endtask

    task automatic t_reset();
        check_eq("R1 count", cnt_now(), 0);
        check_eq("R1 flag", int'(ovf_flag), 0);
        check_eq("R1 irq", int'(irq), 0);
    endtask

    task automatic t_timer_std();
        x2_en = 1'b0; evt_mode = 1'b0; gate_en = 1'b0; gate_pin = 1'b0;
        run_en = 1'b1;
        step(59);
        check_eq("R2 one edge before step", cnt_now(), 4);
        step(1);
        check_eq("R2 at step, gate_pin low ignored R9", cnt_now(), 5);
        run_en = 1'b0;
        step(30);
        check_eq("R7 hold while stopped", cnt_now(), 5);
        run_en = 1'b1;
        step(11);
        check_eq("R7 divider restarted", cnt_now(), 5);
        step(1);
        check_eq("R7 resume from held value", cnt_now(), 6);
        run_en = 1'b0;
        step(2);
    endtask

    task automatic t_timer_x2();
        write_byte(1'b0, 8'h00);
        write_byte(1'b1, 8'h00);
        x2_en = 1'b1;
        run_en = 1'b1;
        step(29);
        check_eq("R3 one edge before step", cnt_now(), 4);
        step(1);
        check_eq("R3 at step", cnt_now(), 5);
        run_en = 1'b0;
        step(2);
    endtask

    task automatic t_cascade();
        write_byte(1'b0, 8'hFE);
        write_byte(1'b1, 8'h12);
        check_eq("R10 preset both bytes", cnt_now(), 16'h12FE);
        x2_en = 1'b1;
        run_en = 1'b1;
        step(6);
        check_eq("R4 low byte full", cnt_now(), 16'h12FF);
        step(6);
        check_eq("R4 carry into high byte", cnt_now(), 16'h1300);
        run_en = 1'b0;
        step(2);
    endtask

    task automatic t_overflow();
        write_byte(1'b0, 8'hFF);
        write_byte(1'b1, 8'hFF);
        x2_en = 1'b1;
        run_en = 1'b1;
        step(5);
        check_eq("R5 no flag before wrap", int'(ovf_flag), 0);
        step(1);
        check_eq("R5 wrap to zero", cnt_now(), 0);
        check_eq("R5 flag set", int'(ovf_flag), 1);
        check_eq("R5 irq high", int'(irq), 1);
        step(6);
        check_eq("R6 flag sticky", int'(ovf_flag), 1);
        check_eq("R6 count continues", cnt_now(), 1);
        run_en = 1'b0;
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        check_eq("R6 ack clears", int'(ovf_flag), 0);
        check_eq("R6 irq low after ack", int'(irq), 0);
    endtask

    task automatic t_coincide();
        write_byte(1'b0, 8'hFF);
        write_byte(1'b1, 8'hFF);
        run_en = 1'b1;
        step(5);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        check_eq("R6 overflow wins over clear", int'(ovf_flag), 1);
        check_eq("R6 count wrapped", cnt_now(), 0);
        run_en = 1'b0;
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        check_eq("R6 software clear", int'(ovf_flag), 0);
    endtask

    task automatic t_counter();
        write_byte(1'b0, 8'h00);
        write_byte(1'b1, 8'h00);
        x2_en = 1'b1; evt_mode = 1'b1; evt_pin = 1'b1;
        step(4);
        run_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            evt_pin = 1'b1;
            step(30);
            evt_pin = 1'b0;
            step(30);
        end
        step(30);
        check_eq("R8 one step per falling edge", cnt_now(), 4);
        run_en = 1'b0; evt_mode = 1'b0;
        step(2);
    endtask

    task automatic t_gate();
        int snap;
        write_byte(1'b0, 8'h00);
        write_byte(1'b1, 8'h00);
        x2_en = 1'b1; gate_en = 1'b1; gate_pin = 1'b0;
        run_en = 1'b1;
        step(60);
        check_eq("R9 gate closed holds", cnt_now(), 0);
        gate_pin = 1'b1;
        step(60);
        check_rng("R9 gate open counts", cnt_now(), 9, 10);
        gate_pin = 1'b0;
        step(5);
        snap = cnt_now();
        step(60);
        check_eq("R9 gate closed again holds", cnt_now(), snap);
        gate_en = 1'b0;
        step(60);
        check_rng("R9 gate_en low ignores pin", cnt_now() - snap, 9, 10);
        run_en = 1'b0;
        step(2);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_timer_std();
        t_timer_x2();
        t_cascade();
        t_overflow();
        t_coincide();
        t_counter();
        t_gate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule